// File: doc/BRIEF.md
# Protection Tuple Generator

This block sits in the write path of a block-storage controller and stamps an eight-byte integrity tuple into the metadata area of every logical block that streams through it. A transfer is a byte stream made of one or more logical blocks. Each block is its data bytes followed directly by its metadata bytes. The block passes every byte through in the same clock cycle. It replaces only the eight tuple bytes, writing a computed guard, an application tag and a reference tag in their place.

A one-cycle start pulse loads the per-transfer settings:
- the data size and metadata size of one block;
- the protection type code;
- whether the tuple sits at the front or the back of the metadata;
- the application tag;
- the first reference tag.

The guard is a 16-bit CRC. It is computed one byte per clock over the block's data and over any metadata bytes that come before the tuple. The reference tag follows the block sequence, except when the type code asks for it to stay fixed. Both stream sides use a valid/ready handshake and carry an end-of-transfer marker on the final byte.

Top module: `prot_tuple_gen`

## Requirements
- R1: While reset is asserted, and afterwards until a start pulse is accepted, `out_valid` and `in_ready` stay 0 whatever `in_valid` and `out_ready` do.
- R2: A start pulse is accepted only while the block is idle. The block latches all `cfg_*` inputs in that cycle. A start pulse during a transfer has no effect: the tuples already being produced keep the application tag, reference tag and placement of the accepted start.
- R3: Data bytes, and metadata bytes outside the tuple, leave on `out_data` equal to `in_data` in the same cycle. `out_last` equals `in_last` for every byte of a transfer.
- R4: The metadata area holds the tuple in one of two places. With `cfg_tuple_first` = 1 it fills metadata offsets 0..7. With `cfg_tuple_first` = 0 it fills offsets M-8..M-1, where M is the metadata size (M >= 8).
- R5: The tuple bytes appear in this order, each field most significant byte first: guard bits 15:8, guard bits 7:0, application tag 15:8, application tag 7:0, reference tag 31:24, 23:16, 15:8, 7:0.
- R6: The guard is a CRC-16 with polynomial 0x8BB7 and initial value 0. It uses no reflection and no final XOR, and feeds each byte most significant bit first. It covers all data bytes of the block and then the metadata bytes before the tuple. It restarts at 0 for every block. For the ASCII bytes "123456789" it is 0xD0DB.
- R7: Every block of a transfer carries the latched application tag.
- R8: The first block carries the latched reference tag. For any type code other than 3, each later block carries the previous value plus 1, modulo 2^32 (so 0xFFFFFFFF is followed by 0). For type code 3 every block carries the same value.
- R9: While a transfer is active, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. A byte counts as consumed only when both `in_valid` and `in_ready` are 1. After the byte flagged `in_last` is consumed, `in_ready` is 0 until the next accepted start.
- R10: A transfer may end part-way through a block. The next accepted start always begins at data byte 0 of a block, with the guard at 0 and the new reference tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| start | input | 1 | Start of transfer; loads the configuration when idle |
| cfg_blk_size | input | BLK_W | Data bytes per logical block |
| cfg_md_size | input | MD_W | Metadata bytes per logical block (at least 8) |
| cfg_prot_type | input | 2 | Protection type code; 3 freezes the reference tag |
| cfg_tuple_first | input | 1 | 1: tuple at front of metadata, 0: at back |
| cfg_app_tag | input | 16 | Application tag for every tuple |
| cfg_ref_tag | input | 32 | Reference tag of the first block |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of the transfer |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take the output byte |
| out_data | output | 8 | Output byte with tuple inserted |
| out_last | output | 1 | Final byte of the transfer |

## Verification
A wrong position count shows up on the first tuple byte that follows it. That byte then carries the wrong field, or a pass-through byte gets overwritten, so comparing every output byte catches the error within one block. A guard register that advances during a stall, or that fails to clear at a block boundary, corrupts the guard bytes of that block or the next one. A reference-tag sequencer that steps wrongly shows up on the reference bytes of the second block, and the wrap from all-ones to zero is exercised on purpose.

// File: rtl/pt_pkg.sv
package pt_pkg;

  localparam int TUPLE_BYTES = 8;
  localparam int GUARD_W     = 16;
  localparam int APP_W       = 16;
  localparam int REF_W       = 32;
  localparam logic [GUARD_W-1:0] GUARD_POLY = 16'h8BB7;

  typedef enum logic [1:0] {
    SEG_DATA,
    SEG_MD_PRE,
    SEG_TUPLE,
    SEG_MD_POST
  } seg_e;

  // One byte of the guard CRC, most significant bit first.
  function automatic logic [GUARD_W-1:0] guard_step(
    input logic [GUARD_W-1:0] crc_in,
    input logic [7:0]         byte_in
  );
    logic [GUARD_W-1:0] c;
    c = crc_in ^ {byte_in, 8'h00};
    for (int i = 0; i < 8; i++) begin
      if (c[GUARD_W-1]) c = {c[GUARD_W-2:0], 1'b0} ^ GUARD_POLY;
      else              c = {c[GUARD_W-2:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/pt_pos_track.sv
module pt_pos_track #(
  parameter int BLK_W = 16,
  parameter int MD_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             clr,
  input  logic             step,
  input  logic [BLK_W-1:0] blk_size,
  input  logic [MD_W-1:0]  md_size,
  input  logic             tuple_first,
  output pt_pkg::seg_e     seg,
  output logic [2:0]       tup_idx,
  output logic             blk_end
);
  import pt_pkg::*;

  localparam int POS_W = ((BLK_W > MD_W) ? BLK_W : MD_W) + 1;

  logic [POS_W-1:0] pos_q, pos_d;
  logic [POS_W-1:0] frame_len, md_off, tup_off, tup_rel;

  always_comb begin
    frame_len = POS_W'(blk_size) + POS_W'(md_size);
    md_off    = pos_q - POS_W'(blk_size);
    tup_off   = tuple_first ? '0 : (POS_W'(md_size) - POS_W'(TUPLE_BYTES));
    tup_rel   = md_off - tup_off;
    blk_end   = (pos_q == frame_len - POS_W'(1));
    tup_idx   = tup_rel[2:0];
    if (pos_q < POS_W'(blk_size))            seg = SEG_DATA;
    else if (md_off < tup_off)               seg = SEG_MD_PRE;
    else if (tup_rel < POS_W'(TUPLE_BYTES))  seg = SEG_TUPLE;
    else                                     seg = SEG_MD_POST;
  end

  always_comb begin
    pos_d = pos_q;
    if (clr)          pos_d = '0;
    else if (step)    pos_d = blk_end ? '0 : (pos_q + POS_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pos_q < frame_len)); // R4

  AST_WRAP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (step && blk_end && !clr) |=> (seg == SEG_DATA || blk_size == '0)); // R10

endmodule

// File: rtl/pt_guard_crc.sv
module pt_guard_crc (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        en,
  input  logic [7:0]                  data,
  output logic [pt_pkg::GUARD_W-1:0]  crc
);
  import pt_pkg::*;

  logic [GUARD_W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = '0;
    else if (en) crc_d = guard_step(crc_q, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/pt_reftag.sv
module pt_reftag (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [pt_pkg::REF_W-1:0]  init,
  input  logic                      adv,
  input  logic                      hold,
  output logic [pt_pkg::REF_W-1:0]  ref_tag
);
  import pt_pkg::*;

  logic [REF_W-1:0] ref_q, ref_d;

  always_comb begin
    ref_d = ref_q;
    if (load)             ref_d = init;
    else if (adv && !hold) ref_d = ref_q + REF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end

  assign ref_tag = ref_q;

  AST_REF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && hold && !load) |=> $stable(ref_q)); // R8

  AST_REF_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !hold && !load) |=> (ref_q == $past(ref_q) + REF_W'(1))); // R8

endmodule

// File: rtl/prot_tuple_gen.sv
module prot_tuple_gen #(
  parameter int BLK_W = 16,
  parameter int MD_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] cfg_blk_size,
  input  logic [MD_W-1:0]  cfg_md_size,
  input  logic [1:0]       cfg_prot_type,
  input  logic             cfg_tuple_first,
  input  logic [15:0]      cfg_app_tag,
  input  logic [31:0]      cfg_ref_tag,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last
);
  import pt_pkg::*;

  localparam logic [1:0] TYPE_FIXED_REF = 2'd3;

  logic             busy_q, busy_d;
  logic [BLK_W-1:0] blk_q;
  logic [MD_W-1:0]  md_q;
  logic [1:0]       type_q;
  logic             first_q;
  logic [APP_W-1:0] app_q;

  logic               take_start, fire, blk_end, crc_en, crc_clr;
  seg_e               seg;
  logic [2:0]         tup_idx;
  logic [GUARD_W-1:0] guard;
  logic [REF_W-1:0]   ref_tag;

  assign take_start = start && !busy_q;
  assign in_ready   = busy_q && out_ready;
  assign out_valid  = busy_q && in_valid;
  assign out_last   = busy_q && in_last;
  assign fire       = in_valid && in_ready;
  assign crc_clr    = take_start || (fire && blk_end);
  assign crc_en     = fire && (seg == SEG_DATA || seg == SEG_MD_PRE);

  always_comb begin
    busy_d = busy_q;
    if (take_start)           busy_d = 1'b1;
    else if (fire && in_last) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  // configuration holding registers, enabled by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q   <= '0;
      md_q    <= '0;
      type_q  <= '0;
      first_q <= 1'b0;
      app_q   <= '0;
    end else if (take_start) begin
      blk_q   <= cfg_blk_size;
      md_q    <= cfg_md_size;
      type_q  <= cfg_prot_type;
      first_q <= cfg_tuple_first;
      app_q   <= cfg_app_tag;
    end
  end

  pt_pos_track #(.BLK_W(BLK_W), .MD_W(MD_W)) u_pos (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy_q),
    .clr         (take_start),
    .step        (fire),
    .blk_size    (blk_q),
    .md_size     (md_q),
    .tuple_first (first_q),
    .seg         (seg),
    .tup_idx     (tup_idx),
    .blk_end     (blk_end)
  );

  pt_guard_crc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .data  (in_data),
    .crc   (guard)
  );

  pt_reftag u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take_start),
    .init    (cfg_ref_tag),
    .adv     (fire && blk_end),
    .hold    (type_q == TYPE_FIXED_REF),
    .ref_tag (ref_tag)
  );

  // tuple field substitution, fields most significant byte first
  always_comb begin
    out_data = in_data;
    if (seg == SEG_TUPLE) begin
      case (tup_idx)
        3'd0:    out_data = guard[15:8];
        3'd1:    out_data = guard[7:0];
        3'd2:    out_data = app_q[15:8];
        3'd3:    out_data = app_q[7:0];
        3'd4:    out_data = ref_tag[31:24];
        3'd5:    out_data = ref_tag[23:16];
        3'd6:    out_data = ref_tag[15:8];
        default: out_data = ref_tag[7:0];
      endcase
    end
  end

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_last) |=> !in_ready); // R9

  AST_GUARD_HELD_IN_TUPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && seg == SEG_TUPLE && !blk_end) |=> $stable(guard)); // R6

  AST_CFG_KEPT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> ($stable(app_q) && $stable(first_q))); // R2

  AST_NO_OUTPUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q) |-> (!out_valid && !in_ready)); // R1

endmodule

// File: tb/sim_prot_tuple_gen.sv
module sim_prot_tuple_gen;

  typedef struct packed {
    logic [15:0] blk;
    logic [7:0]  md;
    logic [1:0]  ptype;
    logic        first;
    logic [15:0] app;
    logic [31:0] rtag;
    logic [3:0]  nblk;
    logic [7:0]  seed;
    logic        stall;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{16'd16, 8'd8,  2'd1, 1'b1, 16'hA5C3, 32'h0000_0100, 4'd3, 8'h11, 1'b0},
    '{16'd12, 8'd16, 2'd2, 1'b0, 16'h0F0F, 32'h1234_5678, 4'd2, 8'h42, 1'b1},
    '{16'd20, 8'd12, 2'd3, 1'b0, 16'hBEEF, 32'hCAFE_F00D, 4'd3, 8'h07, 1'b0},
    '{16'd8,  8'd12, 2'd1, 1'b1, 16'h0001, 32'hFFFF_FFFE, 4'd3, 8'hC0, 1'b1},
    '{16'd5,  8'd8,  2'd3, 1'b1, 16'hFFFF, 32'hFFFF_FFFF, 4'd2, 8'h5A, 1'b0},
    '{16'd33, 8'd10, 2'd2, 1'b0, 16'h7777, 32'h0000_0000, 4'd2, 8'h99, 1'b1}
  };

  logic        clk, rst_n, start;
  logic [15:0] cfg_blk_size;
  logic [7:0]  cfg_md_size;
  logic [1:0]  cfg_prot_type;
  logic        cfg_tuple_first;
  logic [15:0] cfg_app_tag;
  logic [31:0] cfg_ref_tag;
  logic        in_valid, in_ready, in_last, out_valid, out_ready, out_last;
  logic [7:0]  in_data, out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  prot_tuple_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_blk_size(cfg_blk_size), .cfg_md_size(cfg_md_size),
    .cfg_prot_type(cfg_prot_type), .cfg_tuple_first(cfg_tuple_first),
    .cfg_app_tag(cfg_app_tag), .cfg_ref_tag(cfg_ref_tag),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bitwise CRC model of R6, written from the polynomial
  function automatic logic [15:0] model_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ b[i];
      r  = r << 1;
      if (fb) r = r ^ 16'h8BB7;
    end
    return r;
  endfunction

  task automatic xfer(input vec_t v, input int poke, input bit ascii, input int trunc);
    logic [15:0] crc;
    logic [31:0] rtag;
    logic [15:0] got_g;
    int total;
    int sent;
    rtag = v.rtag;
    got_g = '0;
    sent = 0;
    @(negedge clk);
    start = 1'b1;
    cfg_blk_size = v.blk; cfg_md_size = v.md; cfg_prot_type = v.ptype;
    cfg_tuple_first = v.first; cfg_app_tag = v.app; cfg_ref_tag = v.rtag;
    @(negedge clk);
    start = 1'b0;
    total = int'(v.nblk) * (int'(v.blk) + int'(v.md));
    if (trunc > 0) total = trunc;
    for (int b = 0; b < int'(v.nblk) && sent < total; b++) begin
      crc = '0;
      for (int p = 0; p < int'(v.blk) + int'(v.md) && sent < total; p++) begin
        logic [7:0] din, exp;
        string req;
        int m, toff, k;
        logic last;
        k = -1;
        if (ascii && p < 9) din = 8'(8'h31 + p);
        else din = 8'(int'(v.seed) + b * 37 + p * 11);
        exp = din;
        req = "R3 pass-through";
        if (p < int'(v.blk)) begin
          crc = model_crc(crc, din);
        end else begin
          m = p - int'(v.blk);
          toff = v.first ? 0 : int'(v.md) - 8;       // R4 placement
          if (m < toff) crc = model_crc(crc, din);
          else if (m < toff + 8) begin
            k = m - toff;
            case (k)
              0: begin exp = crc[15:8];  req = "R5 R6 guard hi"; end
              1: begin exp = crc[7:0];   req = "R5 R6 guard lo"; end
              2: begin exp = v.app[15:8]; req = "R4 R7 app hi"; end
              3: begin exp = v.app[7:0];  req = "R4 R7 app lo"; end
              4: begin exp = rtag[31:24]; req = "R5 R8 ref b3"; end
              5: begin exp = rtag[23:16]; req = "R5 R8 ref b2"; end
              6: begin exp = rtag[15:8];  req = "R5 R8 ref b1"; end
              default: begin exp = rtag[7:0]; req = "R5 R8 ref b0"; end
            endcase
          end
        end
        if (poke >= 0) req = {"R2 ", req};
        last = (sent == total - 1);
        if (v.stall && (p % 5 == 2)) begin
          out_ready = 1'b0; in_valid = 1'b1; in_data = din; in_last = last;
          #1;
          chk("R9 stalled in_ready", {31'd0, in_ready}, 32'd0);
          chk("R9 stalled out_valid", {31'd0, out_valid}, 32'd1);
          @(negedge clk);
          out_ready = 1'b1;
        end
        in_valid = 1'b1; in_data = din; in_last = last;
        if (sent == poke) begin
          start = 1'b1; cfg_app_tag = ~v.app; cfg_ref_tag = 32'h0;
          cfg_tuple_first = ~v.first; cfg_blk_size = v.blk + 16'd1;
        end
        #1;
        chk(req, {24'd0, out_data}, {24'd0, exp});
        chk("R9 out_valid", {31'd0, out_valid}, 32'd1);
        chk("R9 in_ready", {31'd0, in_ready}, 32'd1);
        chk("R3 out_last", {31'd0, out_last}, {31'd0, last});
        if (k == 0) got_g[15:8] = out_data;
        if (k == 1) got_g[7:0] = out_data;
        @(negedge clk);
        start = 1'b0;
        sent++;
      end
      if (v.ptype != 2'd3) rtag = rtag + 32'd1;
    end
    in_valid = 1'b0; in_last = 1'b0;
    #1;
    chk("R9 idle after last", {31'd0, in_ready}, 32'd0);
    if (ascii) chk("R6 R10 check value", {16'd0, got_g}, 32'h0000_D0DB);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    cfg_blk_size = '0; cfg_md_size = '0; cfg_prot_type = '0; cfg_tuple_first = 1'b0;
    cfg_app_tag = '0; cfg_ref_tag = '0;
    in_valid = 1'b1; in_data = 8'h3C; in_last = 1'b0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset in_ready", {31'd0, in_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 idle out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 idle in_ready", {31'd0, in_ready}, 32'd0);
    in_valid = 1'b0;

    for (int i = 0; i < NVEC; i++) xfer(VECS[i], -1, 1'b0, 0);

    // R2: start pulse in the middle of a transfer must be ignored
    xfer(VECS[1], 4, 1'b0, 0);
    xfer(VECS[4], 7, 1'b0, 0);

    // R10: partial transfer, then a fresh one with the known check string
    xfer(VECS[0], -1, 1'b0, 5);
    xfer('{16'd9, 8'd8, 2'd1, 1'b0, 16'h1234, 32'hABCD_0001, 4'd1, 8'h00, 1'b0},
         -1, 1'b1, 0);
    // same string, tuple first and 12 metadata bytes: guard still covers data only
    xfer('{16'd9, 8'd12, 2'd2, 1'b1, 16'h4321, 32'h0000_0010, 4'd1, 8'h00, 1'b1},
         -1, 1'b1, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule